// File: doc/BRIEF.md
# Next-PC Selection and Exception Capture Unit

This unit owns the program counter of a multi-cycle 32-bit RISC core, together with the two registers that record an exception: the faulting instruction address and a cause code. On every clock it can load the PC from one of four places. These are the sequential value the ALU has just produced, the branch target held in the ALU output register, a jump target formed from the current PC and the instruction's index field, or a fixed exception vector.

The PC is written in two cases. The first is when the unconditional write strobe is high. The second is when the conditional strobe is high and the ALU zero flag reports that the two compared operands were equal. The unconditional strobe wins whenever both are raised. When the controller takes an exception, it raises a separate strobe to load the exception PC from the ALU result, which the controller has set up as PC minus 4. Another strobe loads the cause register with a code picked by a one-bit select. The ALU, memory and register file sit outside the block, and all three outputs come straight from registers.

Top module: `next_pc_unit`

## Requirements
- R1: A synchronous active-high reset clears the PC, the exception PC and the cause register to 0 at the next rising edge.
- R2: With a PC write enabled and pc_src = 0, the PC takes alu_result at the next edge.
- R3: With a PC write enabled and pc_src = 1, the PC takes alu_out at the next edge.
- R4: With a PC write enabled and pc_src = 2, the PC takes {pc_q[31:28], ir_index[25:0], 2'b00} at the next edge, where pc_q[31:28] is the PC value before the edge.
- R5: With a PC write enabled and pc_src = 3, the PC takes the constant 32'h8000_0180.
- R6: When pc_wr_cond is high and pc_wr is low, the PC is written only if zero is 1. If zero is 0, the PC keeps its value.
- R7: When pc_wr is high, the PC is written whatever the values of pc_wr_cond and zero are.
- R8: When neither write condition holds, the PC keeps its value whatever the other inputs do.
- R9: When epc_wr is high, the exception PC takes alu_result at the next edge. Otherwise it holds its value.
- R10: When cause_wr is high, the cause register takes 0 if cause_sel = 0 (undefined instruction) or 1 if cause_sel = 1 (arithmetic overflow). Otherwise it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write strobe |
| pc_wr_cond | input | 1 | PC write strobe that takes effect only on the branch condition |
| zero | input | 1 | ALU zero flag; 1 when the compared operands are equal |
| pc_src | input | 2 | Next-PC source: 0 sequential, 1 branch, 2 jump, 3 vector |
| alu_result | input | 32 | Combinational ALU output |
| alu_out | input | 32 | Registered ALU output holding the branch target |
| ir_index | input | 26 | Index field of the instruction register, bits 25:0 |
| epc_wr | input | 1 | Exception PC load strobe |
| cause_wr | input | 1 | Cause register load strobe |
| cause_sel | input | 1 | Cause select: 0 undefined instruction, 1 overflow |
| pc_q | output | 32 | Program counter |
| epc_q | output | 32 | Exception PC |
| cause_q | output | 32 | Exception cause code |

## Verification
The three outputs are the registers themselves, so any corruption of internal state is visible at the ports on the first falling edge after the faulty clock edge. For example, a wrong source decode, a lost priority or a write on a false branch condition shows up as a PC mismatch one cycle after the strobe. A PC that drifts while no write is enabled shows up in the first idle cycle that follows. Faults in the exception registers also appear within one cycle, because the cause code and the captured address are compared on every clock. This includes the cycles in which the strobes are low.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [1:0] {
    NPC_SEQ    = 2'd0,
    NPC_BRANCH = 2'd1,
    NPC_JUMP   = 2'd2,
    NPC_VECTOR = 2'd3
  } npc_src_e;

endpackage

// File: rtl/npc_source_mux.sv
module npc_source_mux
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int JUMP_W = 26,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180,
  localparam int HI_W = XLEN - JUMP_W - 2
) (
  input  npc_src_e          src,
  input  logic [XLEN-1:0]   seq_val,
  input  logic [XLEN-1:0]   branch_val,
  input  logic [HI_W-1:0]   pc_hi,
  input  logic [JUMP_W-1:0] index,
  output logic [XLEN-1:0]   next_val
);

  logic [XLEN-1:0] jump_val;

  generate
    if (HI_W > 0) begin : g_region
      assign jump_val = {pc_hi, index, 2'b00};
    end else begin : g_flat
      assign jump_val = {index[XLEN-3:0], 2'b00};
    end
  endgenerate

  always_comb begin
    unique case (src)
      NPC_SEQ:    next_val = seq_val;
      NPC_BRANCH: next_val = branch_val;
      NPC_JUMP:   next_val = jump_val;
      NPC_VECTOR: next_val = VECTOR;
      default:    next_val = seq_val;
    endcase
  end

endmodule

// File: rtl/pc_write_ctrl.sv
module pc_write_ctrl (
  input  logic wr_always,
  input  logic wr_cond,
  input  logic cond_ok,
  output logic wr_en
);

  // Unconditional strobe dominates; conditional one needs the flag.
  always_comb begin
    if (wr_always) wr_en = 1'b1;
    else           wr_en = wr_cond & cond_ok;
  end

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    en |=> q == $past(d));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] CODE_UNDEF = '0,
  parameter logic [XLEN-1:0] CODE_OVF = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            epc_wr,
  input  logic [XLEN-1:0] epc_d,
  input  logic            cause_wr,
  input  logic            cause_sel,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] cause_q
);

  logic [XLEN-1:0] cause_d;

  assign cause_d = cause_sel ? CODE_OVF : CODE_UNDEF;

  always_ff @(posedge clk) begin
    if (rst)         epc_q <= '0;
    else if (epc_wr) epc_q <= epc_d;
  end

  always_ff @(posedge clk) begin
    if (rst)           cause_q <= '0;
    else if (cause_wr) cause_q <= cause_d;
  end

  p_epc_load_r9: assert property (@(posedge clk) disable iff (rst)
    epc_wr |=> epc_q == $past(epc_d));

  p_epc_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !epc_wr |=> $stable(epc_q));

  p_cause_code_r10: assert property (@(posedge clk) disable iff (rst)
    cause_wr |=> cause_q == ($past(cause_sel) ? CODE_OVF : CODE_UNDEF));

  p_cause_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !cause_wr |=> $stable(cause_q));

  p_clear_r1: assert property (@(posedge clk)
    rst |=> (epc_q == '0) && (cause_q == '0));

endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int JUMP_W = 26,
  parameter logic [XLEN-1:0] VECTOR = 32'h8000_0180,
  parameter logic [XLEN-1:0] CAUSE_UNDEF = '0,
  parameter logic [XLEN-1:0] CAUSE_OVF = 1,
  localparam int HI_W = XLEN - JUMP_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic              zero,
  input  logic [1:0]        pc_src,
  input  logic [XLEN-1:0]   alu_result,
  input  logic [XLEN-1:0]   alu_out,
  input  logic [JUMP_W-1:0] ir_index,
  input  logic              epc_wr,
  input  logic              cause_wr,
  input  logic              cause_sel,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   epc_q,
  output logic [XLEN-1:0]   cause_q
);

  logic [XLEN-1:0] pc_next;
  logic            pc_en;

  npc_source_mux #(.XLEN(XLEN), .JUMP_W(JUMP_W), .VECTOR(VECTOR)) u_mux (
    .src        (npc_src_e'(pc_src)),
    .seq_val    (alu_result),
    .branch_val (alu_out),
    .pc_hi      (pc_q[XLEN-1 -: HI_W]),
    .index      (ir_index),
    .next_val   (pc_next)
  );

  pc_write_ctrl u_wctl (
    .wr_always (pc_wr),
    .wr_cond   (pc_wr_cond),
    .cond_ok   (zero),
    .wr_en     (pc_en)
  );

  pc_reg #(.XLEN(XLEN)) u_pc (
    .clk (clk),
    .rst (rst),
    .en  (pc_en),
    .d   (pc_next),
    .q   (pc_q)
  );

  exc_capture #(.XLEN(XLEN), .CODE_UNDEF(CAUSE_UNDEF), .CODE_OVF(CAUSE_OVF)) u_exc (
    .clk       (clk),
    .rst       (rst),
    .epc_wr    (epc_wr),
    .epc_d     (alu_result),
    .cause_wr  (cause_wr),
    .cause_sel (cause_sel),
    .epc_q     (epc_q),
    .cause_q   (cause_q)
  );

  p_pc_clear_r1: assert property (@(posedge clk)
    rst |=> pc_q == '0);

  p_branch_src_r3: assert property (@(posedge clk) disable iff (rst)
    pc_wr && pc_src == 2'd1 |=> pc_q == $past(alu_out));

  p_jump_src_r4: assert property (@(posedge clk) disable iff (rst)
    pc_wr && pc_src == 2'd2 |=>
      pc_q == {$past(pc_q[XLEN-1 -: HI_W]), $past(ir_index), 2'b00});

  p_vector_src_r5: assert property (@(posedge clk) disable iff (rst)
    pc_wr && pc_src == 2'd3 |=> pc_q == VECTOR);

  p_cond_skip_r6: assert property (@(posedge clk) disable iff (rst)
    !pc_wr && pc_wr_cond && !zero |=> $stable(pc_q));

  p_priority_r7: assert property (@(posedge clk) disable iff (rst)
    pc_wr && pc_wr_cond && !zero && pc_src == 2'd0 |=> pc_q == $past(alu_result));

endmodule

// File: tb/sim_next_pc_unit.sv
module sim_next_pc_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pc_wr = 1'b0, pc_wr_cond = 1'b0, zero = 1'b0;
  logic [1:0]  pc_src = 2'd0;
  logic [31:0] alu_result = '0, alu_out = '0;
  logic [25:0] ir_index = '0;
  logic        epc_wr = 1'b0, cause_wr = 1'b0, cause_sel = 1'b0;
  logic [31:0] pc_q, epc_q, cause_q;

  int checks = 0;
  int fails = 0;

  logic [31:0] m_pc = '0, m_epc = '0, m_cause = '0;

  always #10 clk = ~clk;

  next_pc_unit u0 (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .zero(zero),
    .pc_src(pc_src), .alu_result(alu_result), .alu_out(alu_out), .ir_index(ir_index),
    .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_sel(cause_sel),
    .pc_q(pc_q), .epc_q(epc_q), .cause_q(cause_q)
  );

  // Behavioural reference, updated on the same edge as the design.
  always @(posedge clk) begin
    if (rst) begin
      m_pc <= 0; m_epc <= 0; m_cause <= 0;
    end else begin
      if (pc_wr || (pc_wr_cond && zero)) begin
        case (pc_src)
          2'd0: m_pc <= alu_result;
          2'd1: m_pc <= alu_out;
          2'd2: m_pc <= {m_pc[31:28], ir_index, 2'b00};
          default: m_pc <= 32'h8000_0180;
        endcase
      end
      if (epc_wr) m_epc <= alu_result;
      if (cause_wr) m_cause <= cause_sel ? 32'd1 : 32'd0;
    end
  end

  task automatic cycle(input string tag);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (pc_q !== m_pc || epc_q !== m_epc || cause_q !== m_cause) begin
      fails++;
      $display("FAIL %s pc=%h/%h epc=%h/%h cause=%h/%h (actual/expected)",
               tag, pc_q, m_pc, epc_q, m_epc, cause_q, m_cause);
    end
  endtask

  task automatic idle();
    pc_wr = 0; pc_wr_cond = 0; epc_wr = 0; cause_wr = 0;
  endtask

  function automatic string pick_tag();
    if (rst) return "R1";
    if (pc_wr && pc_wr_cond) return "R7";
    if (!pc_wr && pc_wr_cond) return "R6";
    if (pc_wr) begin
      case (pc_src)
        2'd0: return "R2";
        2'd1: return "R3";
        2'd2: return "R4";
        default: return "R5";
      endcase
    end
    if (epc_wr) return "R9";
    if (cause_wr) return "R10";
    return "R8";
  endfunction

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - (fails > checks ? checks : fails), checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    alu_result = 32'hDEAD_BEEF; pc_wr = 1; epc_wr = 1; cause_wr = 1; cause_sel = 1;
    cycle("R1");
    cycle("R1");
    rst = 0;
    idle();
    // R2 sequential source
    pc_wr = 1; pc_src = 2'd0; alu_result = 32'h0000_0004;
    cycle("R2");
    // R3 branch target
    pc_src = 2'd1; alu_out = 32'h0040_0040;
    cycle("R3");
    // R4 jump with zero region, then a non-zero region
    pc_src = 2'd2; ir_index = 26'h3FF_FFFF;
    cycle("R4");
    pc_src = 2'd0; alu_result = 32'hA000_0010;
    cycle("R2");
    pc_src = 2'd2; ir_index = 26'h000_0123;
    cycle("R4");
    // R5 exception vector
    pc_src = 2'd3;
    cycle("R5");
    // R6 conditional write
    pc_wr = 0; pc_wr_cond = 1; zero = 1; pc_src = 2'd1; alu_out = 32'h0000_1000;
    cycle("R6");
    zero = 0; alu_out = 32'h0000_2000;
    cycle("R6");
    // R7 priority of unconditional write
    pc_wr = 1; pc_wr_cond = 1; zero = 0; pc_src = 2'd0; alu_result = 32'h0000_3330;
    cycle("R7");
    // R8 no write: every other input toggles
    idle(); pc_src = 2'd3; zero = 1; alu_result = 32'h5555_5555; alu_out = 32'hAAAA_AAAA;
    cycle("R8");
    // R9 exception PC
    epc_wr = 1; alu_result = 32'h0000_332C;
    cycle("R9");
    epc_wr = 0; alu_result = 32'h1111_1111;
    cycle("R9");
    // R10 cause codes
    cause_wr = 1; cause_sel = 1;
    cycle("R10");
    cause_sel = 0;
    cycle("R10");
    cause_wr = 0; cause_sel = 1;
    cycle("R10");
    cause_wr = 1;
    cycle("R10");
    // R1 reset in mid-run
    rst = 1; idle();
    cycle("R1");
    rst = 0;
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      {pc_wr, pc_wr_cond, zero, epc_wr, cause_wr, cause_sel} = 6'($urandom);
      pc_src = 2'($urandom);
      alu_result = $urandom;
      alu_out = $urandom;
      ir_index = 26'($urandom);
      rst = (i % 97 == 96);
      cycle(pick_tag());
    end
    rst = 0; idle();
    cycle("R8");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule